// File: doc/BRIEF.md
# CAN Buffer-Flag Interrupt Register Bank

This block is the slice of a CAN controller's register file that tracks which of the three transmit buffers are free. It also holds the interrupt enables that turn buffer and receiver events into interrupt requests. The CPU reaches it over a byte-wide bus with a 3-bit address, a write strobe and a read strobe. The transmit and receive logic report events on single-cycle pulse inputs: a buffer was released, a buffer was loaded, an overrun happened, or a message arrived.

The bank produces three level interrupt requests, one each for transmit, error and receive. Each request is the registered OR of the flags whose enables are set. The bank watches the controller's initialization handshake. While initialization is both requested and acknowledged, the transmit-empty flags are forced to "all empty". CPU clears of those flags take effect only when neither handshake signal is asserted.

Top module: `canIrqFlagBank`

## Requirements
- R1: After reset the transmit flag register at offset 6 reads 0x07, the transmit enable register at offset 7 reads 0x00, the receive enable register at offset 5 reads 0x00, the receive flag register at offset 4 reads 0x00, and all three interrupt outputs are 0.
- R2: A read with the read strobe high returns, at offset 6, the empty flag of buffer i in bit i (bits 2:0) and 0 in bits 7:3. Reads work at any time, including during initialization. With the read strobe low, the read data is 0x00.
- R3: When both initialization request and acknowledge are 0, writing offset 6 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R4: A write to offset 6 has no effect on the flags while either initialization signal is 1.
- R5: While initialization request and acknowledge are both 1, the transmit flags are held at 0x07.
- R6: A release pulse for buffer i sets flag i, and a load pulse for buffer i clears it. When a release pulse coincides with a load pulse or a CPU clear of the same flag, the flag ends up set.
- R7: The transmit enable register (offset 7, bit i enables flag i, upper bits read 0) gates the flags onto the transmit request. The request becomes 1 exactly one cycle after a flag and its enable are both 1, and falls one cycle after no enabled flag remains.
- R8: The receive flag register at offset 4 holds an overrun flag in bit 1 and a receive-full flag in bit 0. An overrun pulse or a receive pulse sets its flag, which stays set until the CPU writes 1 to that bit; a set pulse wins over a same-cycle clear. The receive enable register at offset 5 has the overrun enable in bit 1 and the receive-full enable in bit 0.
- R9: The error request is the registered AND of the overrun flag and its enable. The receive request is the registered AND of the receive-full flag and its enable. Each follows its inputs with one cycle of delay.
- R10: Offsets other than 4, 5, 6 and 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| initReq | input | 1 | Initialization requested |
| initAck | input | 1 | Initialization acknowledged |
| txRelease | input | 3 | Per-buffer pulse: buffer freed |
| txLoad | input | 3 | Per-buffer pulse: buffer loaded for sending |
| rxOverrun | input | 1 | Pulse: receive overrun |
| rxFull | input | 1 | Pulse: message received |
| txIrq | output | 1 | Transmit interrupt request |
| errIrq | output | 1 | Error interrupt request |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The clear path is tried with data patterns that mix 1s and 0s across the flag bits and also set the unused upper bits. This separates true write-one-to-clear from plain write or toggle behaviour. Each of the four handshake combinations is tried on the same write, which separates "held", "locked" and "writable". Coincident release/load and release/CPU-clear pulses expose the wrong priority. Interrupt outputs are sampled both on the cycle the enable lands and on the one after, which pins down the single register stage.

// File: rtl/canIrqPkg.sv
package canIrqPkg;
  localparam int CAN_DATA_W = 8;
  localparam int CAN_NUM_TX = 3;

  typedef struct packed {
    logic                  initHold;
    logic                  wrTxFlag;
    logic                  wrTxEn;
    logic                  wrRxFlag;
    logic                  wrRxEn;
    logic                  rdTxFlag;
    logic                  rdTxEn;
    logic                  rdRxFlag;
    logic                  rdRxEn;
    logic [CAN_NUM_TX-1:0] wrBits;
  } bankStrobeT;
endpackage

// File: rtl/canIrqCtrl.sv
module canIrqCtrl
  import canIrqPkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = CAN_DATA_W,
  parameter int NUM_TX       = CAN_NUM_TX,
  parameter int RX_FLAG_OFS  = 4,
  parameter int RX_EN_OFS    = 5,
  parameter int TX_FLAG_OFS  = 6,
  parameter int TX_EN_OFS    = 7
) (
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              initReq,
  input  logic              initAck,
  output bankStrobeT        strb
);
  localparam logic [ADDR_W-1:0] A_RXF = ADDR_W'(RX_FLAG_OFS);
  localparam logic [ADDR_W-1:0] A_RXE = ADDR_W'(RX_EN_OFS);
  localparam logic [ADDR_W-1:0] A_TXF = ADDR_W'(TX_FLAG_OFS);
  localparam logic [ADDR_W-1:0] A_TXE = ADDR_W'(TX_EN_OFS);

  logic flagWriteOk;
  logic unusedWrBits;

  assign flagWriteOk  = !initReq && !initAck;
  assign unusedWrBits = ^wrData[DATA_W-1:NUM_TX];

  always_comb begin
    strb          = '0;
    strb.initHold = initReq && initAck;
    strb.wrTxFlag = wrEn && (addr == A_TXF) && flagWriteOk;
    strb.wrTxEn   = wrEn && (addr == A_TXE);
    strb.wrRxFlag = wrEn && (addr == A_RXF);
    strb.wrRxEn   = wrEn && (addr == A_RXE);
    strb.rdTxFlag = rdEn && (addr == A_TXF);
    strb.rdTxEn   = rdEn && (addr == A_TXE);
    strb.rdRxFlag = rdEn && (addr == A_RXF);
    strb.rdRxEn   = rdEn && (addr == A_RXE);
    strb.wrBits   = wrData[NUM_TX-1:0];
  end
endmodule

// File: rtl/canIrqDatapath.sv
module canIrqDatapath
  import canIrqPkg::*;
#(
  parameter int DATA_W = CAN_DATA_W,
  parameter int NUM_TX = CAN_NUM_TX
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobeT        strb,
  input  logic [NUM_TX-1:0] txRelease,
  input  logic [NUM_TX-1:0] txLoad,
  input  logic              rxOverrun,
  input  logic              rxFull,
  output logic [DATA_W-1:0] rdData,
  output logic              txIrq,
  output logic              errIrq,
  output logic              rxIrq
);
  localparam int RX_BITS = 2;
  localparam int OVR_BIT = 1;
  localparam int RXF_BIT = 0;

  logic [NUM_TX-1:0]  txFlags;
  logic [NUM_TX-1:0]  txEn;
  logic [RX_BITS-1:0] rxFlags;
  logic [RX_BITS-1:0] rxEn;
  logic [RX_BITS-1:0] rxSet;

  assign rxSet = {rxOverrun, rxFull};

  for (genvar i = 0; i < NUM_TX; i++) begin : gTxFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txFlags[i] <= 1'b1;
      end else if (strb.initHold || txRelease[i]) begin
        txFlags[i] <= 1'b1;
      end else if (txLoad[i] || (strb.wrTxFlag && strb.wrBits[i])) begin
        txFlags[i] <= 1'b0;
      end
    end

    AST_RELEASE_SETS: assert property (@(posedge clk) disable iff (!rstN)
      txRelease[i] |=> txFlags[i]); // R6
  end

  for (genvar j = 0; j < RX_BITS; j++) begin : gRxFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxFlags[j] <= 1'b0;
      end else if (rxSet[j]) begin
        rxFlags[j] <= 1'b1;
      end else if (strb.wrRxFlag && strb.wrBits[j]) begin
        rxFlags[j] <= 1'b0;
      end
    end

    AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (rxFlags[j] && !strb.wrRxFlag) |=> rxFlags[j]); // R8
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn <= '0;
      rxEn <= '0;
    end else begin
      if (strb.wrTxEn) txEn <= strb.wrBits[NUM_TX-1:0];
      if (strb.wrRxEn) rxEn <= strb.wrBits[RX_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq  <= 1'b0;
      errIrq <= 1'b0;
      rxIrq  <= 1'b0;
    end else begin
      txIrq  <= |(txFlags & txEn);
      errIrq <= rxFlags[OVR_BIT] && rxEn[OVR_BIT];
      rxIrq  <= rxFlags[RXF_BIT] && rxEn[RXF_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.rdTxFlag) rdData = {{(DATA_W-NUM_TX){1'b0}}, txFlags};
    if (strb.rdTxEn)   rdData = {{(DATA_W-NUM_TX){1'b0}}, txEn};
    if (strb.rdRxFlag) rdData = {{(DATA_W-RX_BITS){1'b0}}, rxFlags};
    if (strb.rdRxEn)   rdData = {{(DATA_W-RX_BITS){1'b0}}, rxEn};
  end

  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.initHold |=> (txFlags == '1)); // R5
  AST_TX_IRQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (|(txFlags & txEn)) |=> txIrq); // R7
  AST_TX_IRQ_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !(|(txFlags & txEn)) |=> !txIrq); // R7
  AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlags[OVR_BIT] && rxEn[OVR_BIT]) |=> errIrq); // R9
  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdTxFlag |-> (rdData[DATA_W-1:NUM_TX] == '0)); // R2
endmodule

// File: rtl/canIrqFlagBank.sv
module canIrqFlagBank
  import canIrqPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = CAN_DATA_W,
  parameter int NUM_TX = CAN_NUM_TX
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              initReq,
  input  logic              initAck,
  input  logic [NUM_TX-1:0] txRelease,
  input  logic [NUM_TX-1:0] txLoad,
  input  logic              rxOverrun,
  input  logic              rxFull,
  output logic              txIrq,
  output logic              errIrq,
  output logic              rxIrq
);
  bankStrobeT strb;

  canIrqCtrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_TX(NUM_TX)
  ) uCtrl (
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .initReq(initReq),
    .initAck(initAck),
    .strb   (strb)
  );

  canIrqDatapath #(
    .DATA_W(DATA_W),
    .NUM_TX(NUM_TX)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .txRelease(txRelease),
    .txLoad   (txLoad),
    .rxOverrun(rxOverrun),
    .rxFull   (rxFull),
    .rdData   (rdData),
    .txIrq    (txIrq),
    .errIrq   (errIrq),
    .rxIrq    (rxIrq)
  );
endmodule

// File: tb/canIrqFlagBank_test.sv
module canIrqFlagBank_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       initReq = 1'b0;
  logic       initAck = 1'b0;
  logic [2:0] txRelease = '0;
  logic [2:0] txLoad = '0;
  logic       rxOverrun = 1'b0;
  logic       rxFull = 1'b0;
  logic       txIrq;
  logic       errIrq;
  logic       rxIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  canIrqFlagBank uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .initReq(initReq), .initAck(initAck),
    .txRelease(txRelease), .txLoad(txLoad), .rxOverrun(rxOverrun),
    .rxFull(rxFull), .txIrq(txIrq), .errIrq(errIrq), .rxIrq(rxIrq)
  );

  // {req[3:0], isWrite, addr[2:0], data[7:0], expected[7:0]}
  localparam int NVEC = 19;
  localparam logic [23:0] VEC [NVEC] = '{
    {4'd1, 1'b0, 3'd6, 8'h00, 8'h07},  // R1 flags start empty
    {4'd1, 1'b0, 3'd7, 8'h00, 8'h00},  // R1
    {4'd1, 1'b0, 3'd5, 8'h00, 8'h00},  // R1
    {4'd1, 1'b0, 3'd4, 8'h00, 8'h00},  // R1
    {4'd3, 1'b1, 3'd6, 8'h02, 8'h00},  // R3 clear buffer 1
    {4'd3, 1'b0, 3'd6, 8'h00, 8'h05},  // R3
    {4'd3, 1'b1, 3'd6, 8'h00, 8'h00},  // R3 zeros change nothing
    {4'd3, 1'b0, 3'd6, 8'h00, 8'h05},  // R3
    {4'd3, 1'b1, 3'd6, 8'hF5, 8'h00},  // R3 upper bits ignored
    {4'd2, 1'b0, 3'd6, 8'h00, 8'h00},  // R2
    {4'd7, 1'b1, 3'd7, 8'hFF, 8'h00},  // R7
    {4'd7, 1'b0, 3'd7, 8'h00, 8'h07},  // R7
    {4'd8, 1'b1, 3'd5, 8'hFF, 8'h00},  // R8
    {4'd8, 1'b0, 3'd5, 8'h00, 8'h03},  // R8
    {4'd7, 1'b1, 3'd7, 8'h00, 8'h00},
    {4'd8, 1'b1, 3'd5, 8'h00, 8'h00},
    {4'd7, 1'b0, 3'd7, 8'h00, 8'h00},  // R7
    {4'd10, 1'b1, 3'd3, 8'hAA, 8'h00}, // R10
    {4'd10, 1'b0, 3'd3, 8'h00, 8'h00}  // R10
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [2:0] a, input logic [7:0] exp);
    addr = a; rdEn = 1'b1;
    #1;
    check(tag, rdData, exp);
    rdEn = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    check("R1 txIrq", {7'd0, txIrq}, 8'h00);
    check("R1 errIrq", {7'd0, errIrq}, 8'h00);
    check("R1 rxIrq", {7'd0, rxIrq}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][19]) writeReg(VEC[i][18:16], VEC[i][15:8]);
      else readCheck($sformatf("R%0d vec%0d", VEC[i][23:20], i), VEC[i][18:16], VEC[i][7:0]);
    end

    // flags now 000
    addr = 3'd6; rdEn = 1'b0; #1;
    check("R2 no strobe", rdData, 8'h00);
    txRelease = 3'b010; tick(1); txRelease = '0;
    readCheck("R6 release", 3'd6, 8'h02);
    txLoad = 3'b010; tick(1); txLoad = '0;
    readCheck("R6 load", 3'd6, 8'h00);
    txRelease = 3'b001; txLoad = 3'b001; tick(1); txRelease = '0; txLoad = '0;
    readCheck("R6 release beats load", 3'd6, 8'h01);
    txRelease = 3'b100; writeReg(3'd6, 8'h04); txRelease = '0;
    readCheck("R6 release beats clear", 3'd6, 8'h05);

    initReq = 1'b1;
    writeReg(3'd6, 8'h07);
    readCheck("R4 req only", 3'd6, 8'h05);
    initReq = 1'b0; initAck = 1'b1;
    writeReg(3'd6, 8'h07);
    readCheck("R4 ack only", 3'd6, 8'h05);
    initReq = 1'b1;
    tick(1);
    readCheck("R5 held", 3'd6, 8'h07);
    txLoad = 3'b001; writeReg(3'd6, 8'h07); txLoad = '0;
    readCheck("R5 held against load and write", 3'd6, 8'h07);
    initReq = 1'b0; initAck = 1'b0;
    writeReg(3'd6, 8'h03);
    readCheck("R3 after init", 3'd6, 8'h04);

    writeReg(3'd7, 8'h04);
    check("R7 latency", {7'd0, txIrq}, 8'h00);
    tick(1);
    check("R7 raise", {7'd0, txIrq}, 8'h01);
    writeReg(3'd6, 8'h04);
    check("R7 still high", {7'd0, txIrq}, 8'h01);
    tick(1);
    check("R7 fall", {7'd0, txIrq}, 8'h00);

    rxOverrun = 1'b1; tick(1); rxOverrun = 1'b0;
    tick(1);
    check("R9 masked overrun", {7'd0, errIrq}, 8'h00);
    readCheck("R8 overrun flag", 3'd4, 8'h02);
    writeReg(3'd5, 8'h02);
    tick(1);
    check("R9 errIrq", {7'd0, errIrq}, 8'h01);
    rxFull = 1'b1; tick(1); rxFull = 1'b0;
    tick(1);
    check("R9 masked rxFull", {7'd0, rxIrq}, 8'h00);
    writeReg(3'd5, 8'h03);
    tick(1);
    check("R9 rxIrq", {7'd0, rxIrq}, 8'h01);
    writeReg(3'd4, 8'h02);
    readCheck("R8 w1c", 3'd4, 8'h01);
    tick(1);
    check("R9 errIrq drops", {7'd0, errIrq}, 8'h00);
    rxFull = 1'b1; writeReg(3'd4, 8'h01); rxFull = 1'b0;
    readCheck("R8 set wins", 3'd4, 8'h01);
    readCheck("R10 unmapped", 3'd0, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule